// File: doc/BRIEF.md
# Two-Wire Control Slave for a 10-Bit Current-Sink DAC

This block is the digital front end of a current-sink digital-to-analog converter. It listens on a two-wire serial bus as a slave device. The block samples SCL and SDA with the system clock and filters out short spikes on both lines. It then finds the start and stop conditions and decodes a 7-bit device address. The two low bits of that address are ignored. A bus master reaches the block with exactly two data bytes per transfer. These bytes form a 16-bit input word: bit 15 is a software power-down flag, bit 14 is unused, bits 13..4 hold the 10-bit converter code, and bits 3..0 are unused.

A write is sent high byte first. The first byte goes into the upper half of the input word and the second byte into the lower half. The converter code and the power-down flag are taken from the input word only once the second byte has been acknowledged. A read returns the same 16 bits in the same order, and afterwards the input word is cleared to zero. The power-down output is the software flag ORed with an asynchronous, active-low shutdown pin. The block drives SDA only through an open-drain pull-low output. The analog converter and the pad drivers sit outside this block.

Top module: `vcm_dac_i2c_slave`

## Requirements
- R1: The block answers a 7-bit address whose upper five bits equal 5'b00011, whatever its two low bits are (0x0C to 0x0F). It acknowledges the address by pulling SDA low during the ninth SCL pulse. The eighth address bit selects the direction: 0 is write and 1 is read.
- R2: A falling SDA while SCL is high is a start condition, and a rising SDA while SCL is high is a stop condition. Either one abandons whatever transfer is in progress. The block changes its SDA drive only while the filtered SCL is low.
- R3: Write data is shifted in MSB first. The first byte fills input word bits 15..8 and the second byte fills bits 7..0. After the second byte is acknowledged, input bits 13..4 appear on `dac_code_o` and input bit 15 becomes the software power-down. Bits 14 and 3..0 have no effect on either output.
- R4: A write that ends with a stop or a repeated start before its second byte is acknowledged leaves `dac_code_o` and the software power-down unchanged.
- R5: A read returns the input word as two bytes, bits 15..8 first and MSB first, with SDA low meaning 0. Once the second byte has been sent, the input word is cleared to zero, so a following read returns 0x00, 0x00. A read never changes `dac_code_o`.
- R6: After a synchronous reset, `dac_code_o` is zero, the software power-down is clear and SDA is released.
- R7: `pwr_down_o` is high whenever `shdn_n_i` is low, with no clock edge needed, or whenever the latched software power-down bit is set.
- R8: A pulse on SCL or SDA shorter than FILT_N system clocks has no effect on the decoded bus traffic.
- R9: Both data bytes of a write are acknowledged. A third byte in the same transfer is not acknowledged and is discarded. A non-matching address gets no acknowledge, and the data bytes that follow it are ignored.
- R10: During a read, SDA is released during the master's acknowledge slot after each byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad (resolved wire) |
| shdn_n_i | input | 1 | Asynchronous active-low shutdown pin |
| sda_low_o | output | 1 | High when the block pulls SDA low (open-drain enable) |
| dac_code_o | output | 10 | Converter code held in the DAC register |
| pwr_down_o | output | 1 | Effective power-down: software flag OR shutdown pin |

## Verification
The write path is driven with all four matching addresses and with two non-matching ones. Each data word sets or clears different field bits, including the unused bits 14 and 3..0. This separates a decoder that ignores the two low address bits from one that compares all seven, and a correct field extraction from a code shifted by one bit. Reads are run back to back to tell a cleared input word from a retained one. Truncated writes, a repeated start, a third byte and a short SCL glitch inside a byte show whether the commit waits for exactly the second acknowledge and whether the bit count survives noise.

// File: rtl/dacslv_pkg.sv
package dacslv_pkg;
  // bus-side sequencing of the slave
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_A,
    ST_WDATA,
    ST_ACK_W,
    ST_RDATA,
    ST_ACK_R,
    ST_SKIP
  } bus_st_e;

  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
endpackage

// File: rtl/dacslv_line_filter.sv
module dacslv_line_filter #(
  parameter int FILT_N = 16,
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic clean_o
);
  localparam int CNT_W = (FILT_N > 1) ? $clog2(FILT_N) : 1;

  logic [SYNC_N-1:0] sync_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              samp;

  assign samp = sync_q[SYNC_N-1];

  // a new level is accepted only after FILT_N equal samples in a row
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= '1;
      cnt_q   <= '0;
      clean_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], raw_i};
      if (samp != clean_o) begin
        if (cnt_q == CNT_W'(FILT_N - 1)) begin
          clean_o <= samp;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end
endmodule

// File: rtl/dacslv_bus_engine.sv
module dacslv_bus_engine
  import dacslv_pkg::*;
#(
  parameter int          ADDR_DC     = 2,
  parameter logic [4:0]  DEV_ADDR_HI = 5'b00011
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_f,
  input  logic              sda_f,
  input  logic [WORD_W-1:0] in_word_i,
  output logic              sda_low_o,
  output logic              byte_we_o,
  output logic              byte_hi_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              commit_o,
  output logic              clear_o
);
  localparam int HI_W  = ADDR_W - ADDR_DC;
  localparam int CNT_W = $clog2(BYTE_W + 1);

  bus_st_e           state_q;
  logic              scl_q, sda_q;
  logic [BYTE_W-1:0] shreg_q;
  logic [WORD_W-1:0] tx_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic              second_q, is_read_q, m_ack_q;
  logic              scl_rise, scl_fall, start_c, stop_c, byte_done;

  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_c   = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_c    = scl_f & scl_q & ~sda_q & sda_f;
  assign byte_done = scl_fall && (bit_cnt_q == CNT_W'(BYTE_W));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
      shreg_q   <= '0;
      tx_q      <= '0;
      bit_cnt_q <= '0;
      second_q  <= 1'b0;
      is_read_q <= 1'b0;
      m_ack_q   <= 1'b0;
      sda_low_o <= 1'b0;
      byte_we_o <= 1'b0;
      byte_hi_o <= 1'b0;
      byte_o    <= '0;
      commit_o  <= 1'b0;
      clear_o   <= 1'b0;
    end else begin
      scl_q     <= scl_f;
      sda_q     <= sda_f;
      byte_we_o <= 1'b0;
      commit_o  <= 1'b0;
      clear_o   <= 1'b0;
      if (start_c) begin
        state_q   <= ST_ADDR;
        bit_cnt_q <= '0;
        second_q  <= 1'b0;
        sda_low_o <= 1'b0;
      end else if (stop_c) begin
        state_q   <= ST_IDLE;
        sda_low_o <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR: begin
            if (scl_rise) begin
              shreg_q   <= {shreg_q[BYTE_W-2:0], sda_f};
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (byte_done) begin
              bit_cnt_q <= '0;
              if (shreg_q[BYTE_W-1 -: HI_W] == DEV_ADDR_HI) begin
                is_read_q <= shreg_q[0];
                sda_low_o <= 1'b1;
                state_q   <= ST_ACK_A;
              end else begin
                state_q <= ST_SKIP;
              end
            end
          end
          ST_ACK_A: begin
            if (scl_fall) begin
              if (is_read_q) begin
                tx_q      <= in_word_i;
                sda_low_o <= ~in_word_i[WORD_W-1];
                state_q   <= ST_RDATA;
              end else begin
                sda_low_o <= 1'b0;
                state_q   <= ST_WDATA;
              end
            end
          end
          ST_WDATA: begin
            if (scl_rise) begin
              shreg_q   <= {shreg_q[BYTE_W-2:0], sda_f};
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (byte_done) begin
              bit_cnt_q <= '0;
              byte_we_o <= 1'b1;
              byte_hi_o <= ~second_q;
              byte_o    <= shreg_q;
              sda_low_o <= 1'b1;
              state_q   <= ST_ACK_W;
            end
          end
          ST_ACK_W: begin
            if (scl_fall) begin
              sda_low_o <= 1'b0;
              if (second_q) begin
                commit_o <= 1'b1;
                state_q  <= ST_SKIP;
              end else begin
                second_q <= 1'b1;
                state_q  <= ST_WDATA;
              end
            end
          end
          ST_RDATA: begin
            if (scl_rise) begin
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (scl_fall) begin
              tx_q <= {tx_q[WORD_W-2:0], 1'b0};
              if (bit_cnt_q == CNT_W'(BYTE_W)) begin
                bit_cnt_q <= '0;
                sda_low_o <= 1'b0;
                state_q   <= ST_ACK_R;
              end else begin
                sda_low_o <= ~tx_q[WORD_W-2];
              end
            end
          end
          ST_ACK_R: begin
            if (scl_rise) begin
              m_ack_q <= ~sda_f;
            end else if (scl_fall) begin
              if (second_q) begin
                clear_o <= 1'b1;
                state_q <= ST_SKIP;
              end else if (m_ack_q) begin
                second_q  <= 1'b1;
                sda_low_o <= ~tx_q[WORD_W-1];
                state_q   <= ST_RDATA;
              end else begin
                state_q <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dacslv_regfile.sv
module dacslv_regfile
  import dacslv_pkg::*;
#(
  parameter int CODE_W   = 10,
  parameter int CODE_LSB = 4,
  parameter int PD_BIT   = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_we_i,
  input  logic              byte_hi_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              commit_i,
  input  logic              clear_i,
  output logic [WORD_W-1:0] in_word_o,
  output logic [CODE_W-1:0] code_o,
  output logic              soft_pd_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      in_word_o <= '0;
      code_o    <= '0;
      soft_pd_o <= 1'b0;
    end else begin
      if (clear_i) begin
        in_word_o <= '0;
      end else if (byte_we_i) begin
        if (byte_hi_i) in_word_o[WORD_W-1 -: BYTE_W] <= byte_i;
        else           in_word_o[BYTE_W-1:0]         <= byte_i;
      end
      if (commit_i) begin
        code_o    <= in_word_o[CODE_LSB +: CODE_W];
        soft_pd_o <= in_word_o[PD_BIT];
      end
    end
  end
endmodule

// File: rtl/vcm_dac_i2c_slave.sv
module vcm_dac_i2c_slave
  import dacslv_pkg::*;
#(
  parameter int         FILT_N      = 16,
  parameter int         SYNC_N      = 2,
  parameter int         CODE_W      = 10,
  parameter int         CODE_LSB    = 4,
  parameter int         PD_BIT      = 15,
  parameter int         ADDR_DC     = 2,
  parameter logic [4:0] DEV_ADDR_HI = 5'b00011
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              shdn_n_i,
  output logic              sda_low_o,
  output logic [CODE_W-1:0] dac_code_o,
  output logic              pwr_down_o
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw_w, clean_w;
  logic               scl_clean, sda_clean;
  logic               byte_we_w, byte_hi_w, commit_w, clear_w, soft_pd_w;
  logic [BYTE_W-1:0]  byte_w;
  logic [WORD_W-1:0]  in_word_w;

  assign raw_w     = {scl_i, sda_i};
  assign scl_clean = clean_w[1];
  assign sda_clean = clean_w[0];

  for (genvar gi = 0; gi < N_LINES; gi++) begin : g_filt
    dacslv_line_filter #(.FILT_N(FILT_N), .SYNC_N(SYNC_N)) u_filt (
      .clk     (clk),
      .rst     (rst),
      .raw_i   (raw_w[gi]),
      .clean_o (clean_w[gi])
    );
  end

  dacslv_bus_engine #(.ADDR_DC(ADDR_DC), .DEV_ADDR_HI(DEV_ADDR_HI)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .scl_f     (scl_clean),
    .sda_f     (sda_clean),
    .in_word_i (in_word_w),
    .sda_low_o (sda_low_o),
    .byte_we_o (byte_we_w),
    .byte_hi_o (byte_hi_w),
    .byte_o    (byte_w),
    .commit_o  (commit_w),
    .clear_o   (clear_w)
  );

  dacslv_regfile #(.CODE_W(CODE_W), .CODE_LSB(CODE_LSB), .PD_BIT(PD_BIT)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .byte_we_i (byte_we_w),
    .byte_hi_i (byte_hi_w),
    .byte_i    (byte_w),
    .commit_i  (commit_w),
    .clear_i   (clear_w),
    .in_word_o (in_word_w),
    .code_o    (dac_code_o),
    .soft_pd_o (soft_pd_w)
  );

  // the shutdown pin bypasses every register on purpose
  assign pwr_down_o = soft_pd_w | ~shdn_n_i;
endmodule

// File: rtl/dacslv_checker.sv
module dacslv_checker #(
  parameter int CODE_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              shdn_n_i,
  input logic              pwr_down_o,
  input logic              sda_low_o,
  input logic [CODE_W-1:0] dac_code_o,
  input logic              scl_clean,
  input logic              commit_w
);
  // R6: reset leaves a zero code and a released data line
  assert_reset_clears_R6: assert property (@(posedge clk)
    rst |=> (dac_code_o == '0) && !sda_low_o);

  // R7: the shutdown pin always forces power-down
  assert_pin_forces_pd_R7: assert property (@(posedge clk) disable iff (rst)
    !shdn_n_i |-> pwr_down_o);

  // R3 / R4: the code moves only right after a completed write
  assert_code_needs_commit_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(dac_code_o) |-> $past(commit_w));

  // R2: the slave only moves its data drive while the clock is low
  assert_sda_moves_scl_low_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_low_o) |-> !scl_clean);

  // R10: the data drive never rises while the filtered clock is high
  assert_drive_rise_low_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_low_o) |-> !$past(scl_clean));
endmodule

bind vcm_dac_i2c_slave dacslv_checker #(.CODE_W(CODE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .shdn_n_i   (shdn_n_i),
  .pwr_down_o (pwr_down_o),
  .sda_low_o  (sda_low_o),
  .dac_code_o (dac_code_o),
  .scl_clean  (scl_clean),
  .commit_w   (commit_w)
);

// File: tb/vcm_dac_i2c_slave_tb_top.sv
module vcm_dac_i2c_slave_tb_top;
  localparam int Q = 40;  // quarter of an SCL period, in system clocks

  // {addr7, data word, address expected to match}
  localparam logic [23:0] VEC [7] = '{
    {7'h0C, 16'h3FF0, 1'b1},
    {7'h0D, 16'h0010, 1'b1},
    {7'h0E, 16'h8550, 1'b1},
    {7'h0F, 16'h6AAF, 1'b1},
    {7'h1C, 16'h1230, 1'b0},
    {7'h08, 16'hFFFF, 1'b0},
    {7'h0C, 16'h0000, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic shdn_n = 1'b1;
  logic sda_low;
  logic sda_bus;
  logic [9:0] dac_code;
  logic pwr_down;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic last_oe;
  logic [9:0] exp_code = '0;
  logic exp_pd = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  assign sda_bus = sda_m & ~sda_low;

  vcm_dac_i2c_slave dut_i (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl_m),
    .sda_i      (sda_bus),
    .shdn_n_i   (shdn_n),
    .sda_low_o  (sda_low),
    .dac_code_o (dac_code),
    .pwr_down_o (pwr_down)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b;    tick(Q);
    scl_m = 1'b1; tick(Q);
    last_oe = sda_low;
    tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    b = sda_bus;
    tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  // returns 1 when the slave acknowledged
  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic m_ack);
    for (int i = 7; i >= 0; i--) recv_bit(v[i]);
    send_bit(~m_ack);
  endtask

  task automatic write_txn(input logic [6:0] a, input logic [15:0] w, input bit glitch,
                           output logic ack_a, output logic ack1, output logic ack2);
    bus_start();
    send_byte({a, 1'b0}, ack_a);
    if (glitch) begin
      scl_m = 1'b1; tick(5);
      scl_m = 1'b0; tick(Q);
    end
    send_byte(w[15:8], ack1);
    send_byte(w[7:0], ack2);
    bus_stop();
  endtask

  task automatic read_txn(input logic [6:0] a, output logic ack_a,
                          output logic [7:0] hi, output logic [7:0] lo, output logic oe_slot);
    bus_start();
    send_byte({a, 1'b1}, ack_a);
    recv_byte(hi, 1'b1);
    oe_slot = last_oe;
    recv_byte(lo, 1'b0);
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic aa, a1, a2, oe;
    logic [7:0] hi, lo;
    tick(6);
    rst = 1'b0;
    tick(2);
    chk("R6 reset code", 32'(dac_code), 32'h0);
    chk("R6 reset pd", 32'(pwr_down), 32'h0);
    chk("R6 reset sda", 32'(sda_low), 32'h0);

    // vector table: address decode and field extraction (R1 R3 R9)
    for (int i = 0; i < 7; i++) begin
      logic [6:0]  va;
      logic [15:0] vw;
      logic        vm;
      va = VEC[i][23:17];
      vw = VEC[i][16:1];
      vm = VEC[i][0];
      write_txn(va, vw, 1'b0, aa, a1, a2);
      if (vm) begin
        exp_code = vw[13:4];
        exp_pd   = vw[15];
      end
      chk("R1 address ack", 32'(aa), 32'(vm));
      chk("R9 data acks", 32'({a1, a2}), vm ? 32'h3 : 32'h0);
      chk("R3 dac code", 32'(dac_code), 32'(exp_code));
      chk("R3 soft pd", 32'(pwr_down), 32'(exp_pd));
    end

    // R5: read back, then cleared; read does not move the code
    write_txn(7'h0D, 16'h4567, 1'b0, aa, a1, a2);
    chk("R3 code 0x056", 32'(dac_code), 32'h056);
    read_txn(7'h0C, aa, hi, lo, oe);
    chk("R5 read ack", 32'(aa), 32'h1);
    chk("R5 read bytes", 32'({hi, lo}), 32'h4567);
    chk("R10 release on master ack", 32'(oe), 32'h0);
    chk("R5 code kept", 32'(dac_code), 32'h056);
    read_txn(7'h0F, aa, hi, lo, oe);
    chk("R5 cleared word", 32'({hi, lo}), 32'h0000);

    // R4: write cut by a stop after the first byte
    bus_start();
    send_byte(8'h18, aa);
    send_byte(8'hFF, a1);
    bus_stop();
    chk("R4 stop abort ack", 32'({aa, a1}), 32'h3);
    chk("R4 stop abort code", 32'(dac_code), 32'h056);

    // R2 / R4: repeated start abandons the half write, new write completes
    bus_start();
    send_byte(8'h18, aa);
    send_byte(8'h80, a1);
    chk("R4 pre-restart code", 32'(dac_code), 32'h056);
    bus_start();
    send_byte(8'h1A, aa);
    send_byte(8'h12, a1);
    send_byte(8'h30, a2);
    bus_stop();
    chk("R2 restart acks", 32'({aa, a1, a2}), 32'h7);
    chk("R2 restart code", 32'(dac_code), 32'h123);
    chk("R2 restart pd", 32'(pwr_down), 32'h0);

    // R9: third byte is refused and discarded
    bus_start();
    send_byte(8'h18, aa);
    send_byte(8'h00, a1);
    send_byte(8'h50, a2);
    send_byte(8'hAA, oe);
    bus_stop();
    chk("R9 third byte nack", 32'(oe), 32'h0);
    chk("R9 code after extra", 32'(dac_code), 32'h005);

    // R8: short SCL glitch inside the transfer is filtered
    write_txn(7'h0C, 16'h3010, 1'b1, aa, a1, a2);
    chk("R8 glitch acks", 32'({aa, a1, a2}), 32'h7);
    chk("R8 glitch code", 32'(dac_code), 32'h301);

    // R7: shutdown pin acts without a clock edge
    @(negedge clk);
    shdn_n = 1'b0;
    #0.5;
    chk("R7 pin low pd", 32'(pwr_down), 32'h1);
    shdn_n = 1'b1;
    #0.5;
    chk("R7 pin high pd", 32'(pwr_down), 32'h0);
    chk("R7 code untouched", 32'(dac_code), 32'h301);

    // R6: reset in mid operation
    tick(2);
    rst = 1'b1;
    tick(3);
    rst = 1'b0;
    tick(1);
    chk("R6 re-reset code", 32'(dac_code), 32'h0);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule